// File: doc/BRIEF.md
# Flash Page Auto-Program Controller

This controller sits between an asynchronous byte-wide memory bus and the write port of an internal flash array. The bus strobes (chip enable, output enable, write enable, all active low) are brought into the system clock domain through two-flop synchronisers. A write is taken on the rising edge of write enable while chip enable is low. The address and data inputs are sampled at that point, so they must be held stable until then.

A programming sequence starts with the auto-program command byte 0x40 written while the controller is idle. The next write carries the page address, and it is also the first of exactly 128 data bytes. Each data byte goes into a page buffer at the slot given by its low 7 address bits. After the 128th byte the controller checks its per-page "already programmed" flag. If the page has not been programmed, the controller runs a timed programming pass and copies the buffer into the array. If it has, the pass is refused and an error is flagged. Status is read on data bits 7 and 6 with chip enable and output enable low, and it stays readable until the next command write. An erase input clears all page flags.

The state machine has four states, with these transitions:
- IDLE to ADDR: a command byte is written.
- ADDR to LOAD: the address write arrives.
- LOAD to PROG: the 128th byte arrives and the page is fresh.
- LOAD to IDLE: the 128th byte arrives and the page is already programmed (refusal).
- PROG to IDLE: the timer expires.

Top module: `page_prog_ctrl`

## Requirements
- R1: In IDLE, only a write of the data byte 0x40 moves the controller to ADDR. Any other written byte starts nothing and produces no array writes.
- R2: The page number is taken from address bits [12:7] of the second write of the sequence. Address bits [12:7] of later writes do not change which page is programmed.
- R3: Writes 2 through 129 of the sequence are the 128 page bytes. Each is stored at the slot named by address bits [6:0]. The programming pass then issues exactly 128 array writes, placing slot k at array address {page, k}.
- R4: If address bits [6:0] of the second write are not all zero, the page is still programmed, and status bit 6 reads 1 after the pass. An aligned pass ends with bit 6 at 0.
- R5: PROG lasts PROG_CYCLES clocks. During PROG, status bit 7 reads as the complement of bit 7 of the last byte written. After PROG it reads the true value.
- R6: Writes that arrive during PROG are ignored. This includes command bytes. They start no sequence and change neither the array nor the status.
- R7: A page already programmed since the last erase is refused when its 128th byte arrives. The controller makes no array writes and returns to IDLE with status bit 6 set to 1.
- R8: A one-cycle pulse on erase_all clears every page flag, so that a refused page can be programmed again.
- R9: Status bits 7 and 6 stay unchanged across any number of reads. A write in IDLE (a command write) clears bit 6 and leaves bit 7 as it was.
- R10: dout_en is 1 only while the synchronised chip enable and output enable are both low. dout then reads {status7, status6, 6'b000000}. After reset, dout_en and arr_we are 0 and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low; write taken on rising edge |
| addr | input | 13 | Bus address: [12:7] page, [6:0] byte slot |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data carrying status bits 7 and 6 |
| dout_en | output | 1 | Read data drive enable |
| erase_all | input | 1 | Synchronous clear of all page-programmed flags |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 13 | Array byte address |
| arr_data | output | 8 | Array write data |

## Verification
The assertions assume a bus master that holds address and data stable from the fall of write enable until several clocks after its rise. They also assume that chip enable stays low across each write pulse and that strobes change slowly compared with the clock. The stimulus keeps within these assumptions by using fixed-length write and read tasks that hold each level for several clock periods. Page contents, page numbers for the later writes, misaligned starting slots and padding are drawn at random from a fixed seed. Directed cases cover the remaining situations: command bytes during PROG, reprogramming a page, erase, and status retention.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOAD,
        ST_PROG
    } pp_state_e;

    localparam logic [7:0] CMD_AUTO_PROG = 8'h40;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_slot,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot] <= wr_data;
        end
    end

    assign rd_data = mem[rd_slot];
endmodule

// File: rtl/pp_page_flags.sv
module pp_page_flags #(
    parameter int NUM_PAGES = 64,
    localparam int IW       = $clog2(NUM_PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_flag
);
    logic [NUM_PAGES-1:0] done;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                done[g] <= 1'b0;
            end else if (clear) begin
                done[g] <= 1'b0;
            end else if (set_en && (set_idx == IW'(g))) begin
                done[g] <= 1'b1;
            end
        end
    end

    assign rd_flag = done[rd_idx];

    // R8: a clear leaves every flag empty on the next cycle
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (done == '0));
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
    parameter int PAGE_BYTES  = 128,
    parameter int NUM_PAGES   = 64,
    parameter int PROG_CYCLES = 1000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = $clog2(NUM_PAGES),
    localparam int ADDR_W     = OFF_W + PAGE_W,
    localparam int TMR_W      = $clog2(PROG_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              erase_all,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data
);
    import pp_pkg::*;

    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PROG_CYCLES - 1);
    localparam logic [OFF_W-1:0] CNT_LAST = OFF_W'(PAGE_BYTES - 1);

    // strobe synchronisation and write edge detection
    logic ce_s, oe_s, we_s, we_q, wr_evt;

    pp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, oe_n, we_n}),
        .q     ({ce_s, oe_s, we_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_s;
    end

    assign wr_evt = we_s & ~we_q & ~ce_s;

    // state and datapath registers
    pp_state_e         state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              err_q, d7_q, misal_q, rd_q;
    logic              flag_rd, flag_set, buf_we, load_last;
    logic [7:0]        buf_rd;

    assign load_last = (state_q == ST_LOAD) && wr_evt && (cnt_q == CNT_LAST);
    assign buf_we    = wr_evt && ((state_q == ST_ADDR) || (state_q == ST_LOAD));
    assign flag_set  = (state_q == ST_PROG) && (tmr_q == TMR_LAST);

    pp_page_buf #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_slot (addr[OFF_W-1:0]),
        .wr_data (din),
        .rd_slot (tmr_q[OFF_W-1:0]),
        .rd_data (buf_rd)
    );

    pp_page_flags #(.NUM_PAGES(NUM_PAGES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (erase_all),
        .set_en  (flag_set),
        .set_idx (page_q),
        .rd_idx  (page_q),
        .rd_flag (flag_rd)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_evt && (din == CMD_AUTO_PROG)) state_d = ST_ADDR;
            ST_ADDR: if (wr_evt) state_d = ST_LOAD;
            ST_LOAD: if (load_last) state_d = flag_rd ? ST_IDLE : ST_PROG;
            ST_PROG: if (tmr_q == TMR_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            cnt_q   <= '0;
            tmr_q   <= '0;
            err_q   <= 1'b0;
            d7_q    <= 1'b0;
            misal_q <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            rd_q <= ~ce_s & ~oe_s;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_evt) err_q <= 1'b0;
                end
                ST_ADDR: begin
                    if (wr_evt) begin
                        page_q  <= addr[OFF_W +: PAGE_W];
                        misal_q <= (addr[OFF_W-1:0] != '0);
                        cnt_q   <= OFF_W'(1);
                        d7_q    <= din[7];
                    end
                end
                ST_LOAD: begin
                    if (wr_evt) begin
                        cnt_q <= cnt_q + OFF_W'(1);
                        d7_q  <= din[7];
                        tmr_q <= '0;
                        if (load_last && flag_rd) err_q <= 1'b1;
                    end
                end
                ST_PROG: begin
                    tmr_q <= tmr_q + TMR_W'(1);
                    if (tmr_q == TMR_LAST) err_q <= misal_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        arr_we   = (state_q == ST_PROG) && (32'(tmr_q) < PAGE_BYTES);
        arr_addr = {page_q, tmr_q[OFF_W-1:0]};
        arr_data = buf_rd;
        dout_en  = rd_q;
        dout     = 8'h00;
        if (rd_q) begin
            dout = {((state_q == ST_PROG) ? ~d7_q : d7_q), err_q, 6'b000000};
        end
    end

    // R3: array writes begin right after the last page byte is loaded
    assert_arr_start_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_we) |-> ($past(state_q) == ST_LOAD));

    // R2: page number is frozen throughout programming
    assert_page_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(page_q));

    // R6: no write can pull the controller out of PROG before the timer ends
    assert_prog_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && tmr_q != TMR_LAST) |=> (state_q == ST_PROG));

    // R7: a page is never marked programmed a second time without erase
    assert_no_double_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && !erase_all) |-> !flag_rd);

    // R9: error status holds in IDLE unless a write arrived
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE && !$past(wr_evt)) |-> $stable(err_q));
endmodule

// File: tb/test_page_prog_ctrl.sv
module test_page_prog_ctrl;
    localparam int NP    = 64;
    localparam int PROG  = 300;
    localparam int AW    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, erase_all = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout, arr_data;
    logic          dout_en, arr_we;
    logic [AW-1:0] arr_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int arr_cnt = 0;
    logic [7:0] arr_mem [NP*128];
    logic [7:0] exp_pg [128];
    logic       exp_d7 = 1'b0;

    always #2.5 clk = ~clk;

    page_prog_ctrl #(.NUM_PAGES(NP), .PROG_CYCLES(PROG)) i_page_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .erase_all(erase_all), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (arr_we) begin
            arr_mem[arr_addr] <= arr_data;
            arr_cnt <= arr_cnt + 1;
        end
    end

    initial begin
        wait (cycles > 150000);
        $display("FAIL ALL: watchdog expired actual %0d expected below 150000", cycles);
        errors = errors + 1;
        checks = checks + 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] status_of(input logic in_prog, input logic d7, input logic err);
        return {(in_prog ? ~d7 : d7), err, 6'b000000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; din = d; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(output logic [7:0] v, output logic en);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        v = dout; en = dout_en;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // command, then 128 bytes; the first carries the page, later ones random upper bits
    task automatic load_page(input int pg, input int start, input bit pad);
        bus_write(AW'($urandom_range(0, 8191)), 8'h40);
        for (int i = 0; i < 128; i++) begin
            int off = (start + i) % 128;
            int up  = (i == 0) ? pg : $urandom_range(0, NP - 1);
            logic [7:0] b = (pad && i >= 100) ? 8'hFF : 8'($urandom_range(0, 255));
            exp_pg[off] = b;
            exp_d7 = b[7];
            bus_write({6'(up), 7'(off)}, b);
        end
    endtask

    task automatic page_compare(input int pg, input string req);
        int mism = 0;
        for (int j = 0; j < 128; j++) begin
            if (arr_mem[pg*128 + j] !== exp_pg[j]) mism++;
        end
        chk(req, mism, 0);
    endtask

    // full pass: load, poll during PROG, wait, check count, content and status
    task automatic full_pass(input int pg, input int start, input bit pad, input string tag);
        logic [7:0] v; logic en; int base;
        base = arr_cnt;
        load_page(pg, start, pad);
        bus_read(v, en);
        chk({tag, " R5 poll during PROG"}, v, status_of(1'b1, exp_d7, 1'b0));
        repeat (PROG - 60) @(negedge clk);
        bus_read(v, en);
        chk({tag, " R5 still programming"}, v, status_of(1'b1, exp_d7, 1'b0));
        repeat (80) @(negedge clk);
        bus_read(v, en);
        chk({tag, " R4 final status"}, v, status_of(1'b0, exp_d7, start != 0));
        chk({tag, " R3 array write count"}, arr_cnt - base, 128);
        page_compare(pg, {tag, " R3 array content"});
    endtask

    initial begin
        logic [7:0] v, v2; logic en; int base;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 reset dout_en", dout_en, 0);
        chk("R10 reset arr_we", arr_we, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(v, en);
        chk("R10 read enable", en, 1);
        chk("R10 reset status", v, 8'h00);
        repeat (2) @(negedge clk);
        chk("R10 enable drops after read", dout_en, 0);

        // R1: non-command byte starts nothing
        base = arr_cnt;
        bus_write(13'h0180, 8'h12);
        bus_write(13'h0180, 8'h40 ^ 8'h01);
        repeat (20) @(negedge clk);
        chk("R1 no array writes after non-command", arr_cnt - base, 0);

        // R2/R3/R4/R5: aligned pass on page 3 (later writes carry random pages)
        full_pass(3, 0, 1'b0, "R2 page 3");

        // R6: commands during PROG are ignored
        base = arr_cnt;
        load_page(5, 0, 1'b0);
        bus_write(13'h0000, 8'h40);
        bus_write(13'h0A80, 8'h00);
        bus_read(v, en);
        chk("R6 status unchanged by write in PROG", v, status_of(1'b1, exp_d7, 1'b0));
        repeat (PROG + 20) @(negedge clk);
        bus_read(v, en);
        chk("R6 final status", v, status_of(1'b0, exp_d7, 1'b0));
        chk("R6 array write count", arr_cnt - base, 128);
        page_compare(5, "R6 page 5 content");

        // R4: misaligned start, padded with 0xFF
        full_pass(7, 5, 1'b1, "R4 misaligned page 7");

        // R9: status stable across reads; write in IDLE clears bit 6 only
        bus_read(v, en);
        bus_read(v2, en);
        chk("R9 repeated read stable", v2, v);
        bus_write(13'h0000, 8'h00);
        bus_read(v, en);
        chk("R9 command write clears bit6", v, status_of(1'b0, exp_d7, 1'b0));

        // R7: reprogramming page 3 is refused
        base = arr_cnt;
        load_page(3, 0, 1'b0);
        repeat (PROG + 20) @(negedge clk);
        bus_read(v, en);
        chk("R7 refused status", v, status_of(1'b0, exp_d7, 1'b1));
        chk("R7 no array writes", arr_cnt - base, 0);

        // R8: erase then page 3 again
        @(negedge clk); erase_all = 1'b1;
        @(negedge clk); erase_all = 1'b0;
        full_pass(3, 0, 1'b0, "R8 page 3 after erase");

        // random passes on fresh pages
        for (int k = 0; k < 4; k++) begin
            int st = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 127) : 0;
            full_pass(10 + k, st, 1'($urandom_range(0, 1)), "R3 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule